// File: doc/BRIEF.md
# Panel Pixel Output Control Stage

This block is the last stage between a display controller's palette look-up and the panel data pins. It takes post-palette pixels on a valid/ready stream, optionally inverts them (inverse video), optionally forces them to zero (blanking), and presents them on an output stream that feeds the panel data pins. The invert request comes either from a software control bit or from an external pin. That pin is shared with a general-purpose input when it is not used for inversion.

Alongside the data path, the block produces the operating clock from the input clock, with an optional divide-by-two. It also keeps a free-running frame counter, advanced by a frame-start strobe. When the repeat option is on, each wrap of this counter produces a one-cycle pulse that tells the modulation logic to restart its pattern. All state is clocked by the input clock and cleared by an active-low reset.

Stream rules: an input pixel is taken on a rising edge where `pix_in_valid` and `pix_in_ready` are both high. An output pixel leaves on a rising edge where `pix_out_valid` and `pix_out_ready` are both high. `pix_in_ready` is high whenever the output holding register is empty or is being emptied in the same cycle. While the output is stalled, the data and valid stay unchanged. Control bits are sampled at the moment a pixel is accepted.

Top module: `panel_out_stage`

## Requirements
- R1: With `cfg_div2`=0, `clk_op` follows `clk_in`. With `cfg_div2`=1, `clk_op` is a divide-by-two toggle that changes level on every rising edge of `clk_in` and is low in reset.
- R2: A pixel accepted while `cfg_blank`=1 leaves as all zeros, whatever the invert selection is.
- R3: When `cfg_hw_inv_en`=0, or when `panel_active`=1, a pixel accepted with `cfg_sw_inv`=1 leaves bitwise inverted and one accepted with `cfg_sw_inv`=0 leaves unchanged. `shared_pin` has no effect on the data.
- R4: When `cfg_hw_inv_en`=1 and `panel_active`=0, a pixel leaves inverted exactly when `shared_pin`=1 at acceptance, and `cfg_sw_inv` has no effect.
- R5: `gpio_in` equals `shared_pin` when `panel_active`=0 and `cfg_hw_inv_en`=0. Otherwise it reads 0.
- R6: `pix_in_ready` = !`pix_out_valid` || `pix_out_ready`. A stalled output keeps its data and valid. Every accepted pixel leaves exactly once, in order.
- R7: `frame_count` resets to 0 and, on the edge after each `frame_start` cycle, advances by one modulo 2^FRAME_W.
- R8: When `cfg_repeat`=1, the `frame_start` that wraps the count from all-ones to 0 makes `pattern_restart` high for exactly the one cycle in which `frame_count` first reads 0. With `cfg_repeat`=0, `pattern_restart` stays low.
- R9: In reset, `pix_out_valid`, `frame_count` and `pattern_restart` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div2 | input | 1 | Select operating clock = input clock / 2 |
| cfg_blank | input | 1 | Force panel data to zero |
| cfg_repeat | input | 1 | Enable pattern restart on counter wrap |
| cfg_hw_inv_en | input | 1 | Give shared pin the invert role (passive mode) |
| cfg_sw_inv | input | 1 | Software inverse video |
| panel_active | input | 1 | 1 = active panel, 0 = passive panel |
| shared_pin | input | 1 | Invert control or general-purpose input |
| frame_start | input | 1 | One-cycle frame strobe |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel ready |
| pix_in_data | input | PIX_W | Post-palette pixel |
| pix_out_valid | output | 1 | Panel pixel valid |
| pix_out_ready | input | 1 | Panel side ready |
| pix_out_data | output | PIX_W | Panel pixel |
| clk_op | output | 1 | Operating clock |
| gpio_in | output | 1 | Shared pin read as general input |
| frame_count | output | FRAME_W | Frame counter value |
| pattern_restart | output | 1 | Pattern restart pulse |

## Verification
A wrong invert or blank decision shows as a single pixel mismatch. The scoreboard sees it on the first output handshake of that pixel, one cycle after acceptance at the earliest. A stale or corrupted holding register under back-pressure shows as a repeated, lost or reordered pixel at the next completed output transfer. A counter that steps wrongly shows on `frame_count` one cycle after the strobe. An ungated or misplaced restart pulse shows in the cycle the count wraps, which the bench reaches by shrinking the counter width.

// File: rtl/panel_out_pkg.sv
package panel_out_pkg;
  typedef enum logic [1:0] {
    INV_OFF = 2'd0,
    INV_SW  = 2'd1,
    INV_PIN = 2'd2
  } inv_src_e;

  function automatic logic inv_decide(input logic hw_en, input logic active,
                                      input logic sw, input logic pin);
    return (hw_en && !active) ? pin : sw;
  endfunction
endpackage

// File: rtl/po_clk_halver.sv
module po_clk_halver (
  input  logic clk_in,
  input  logic rst_n,
  input  logic div_sel,
  output logic clk_op
);
  logic half_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign clk_op = div_sel ? half_q : clk_in;

  // R1: toggle flips on every input edge
  a_r1_half_toggles: assert property (@(posedge clk_in) disable iff (!rst_n)
    1'b1 |=> (half_q != $past(half_q)));
endmodule

// File: rtl/po_invert_select.sv
module po_invert_select
  import panel_out_pkg::*;
(
  input  logic cfg_hw_inv_en,
  input  logic cfg_sw_inv,
  input  logic panel_active,
  input  logic shared_pin,
  output logic inv_on,
  output logic gpio_in
);
  inv_src_e src;
  logic     pin_owned;

  assign pin_owned = cfg_hw_inv_en && !panel_active;

  always_comb begin
    if (pin_owned)       src = shared_pin ? INV_PIN : INV_OFF;
    else if (cfg_sw_inv) src = INV_SW;
    else                 src = INV_OFF;
  end

  assign inv_on  = (src != INV_OFF);
  assign gpio_in = (!panel_active && !cfg_hw_inv_en) ? shared_pin : 1'b0;

  // R4/R3: selected source agrees with the reference decision
  always_comb begin
    a_r4_src_match: assert (inv_on == inv_decide(cfg_hw_inv_en, panel_active,
                                                  cfg_sw_inv, shared_pin));
  end
endmodule

// File: rtl/po_pixel_stage.sv
module po_pixel_stage #(
  parameter int PIX_W = 18
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             blank,
  input  logic             inv_on,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data
);
  logic             full_q;
  logic [PIX_W-1:0] data_q;
  logic [PIX_W-1:0] shaped;
  logic             take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  genvar b;
  generate
    for (b = 0; b < PIX_W; b++) begin : g_bit
      assign shaped[b] = blank ? 1'b0 : (in_data[b] ^ inv_on);
    end
  endgenerate

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= shaped;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;

  // R2: blanked pixel is zero
  a_r2_blank_zero: assert property (@(posedge clk_in) disable iff (!rst_n)
    (take && blank) |=> (out_valid && out_data == '0));
  // R6: stalled output holds
  a_r6_stall_hold: assert property (@(posedge clk_in) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/po_frame_tally.sv
module po_frame_tally #(
  parameter int FRAME_W = 18
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               repeat_en,
  output logic [FRAME_W-1:0] count,
  output logic               restart
);
  localparam logic [FRAME_W-1:0] LAST = {FRAME_W{1'b1}};

  logic [FRAME_W-1:0] cnt_q;
  logic               rs_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rs_q  <= 1'b0;
    end else begin
      rs_q <= frame_start && repeat_en && (cnt_q == LAST);
      if (frame_start) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count   = cnt_q;
  assign restart = rs_q;

  // R7: one step per strobe
  a_r7_count_step: assert property (@(posedge clk_in) disable iff (!rst_n)
    frame_start |=> (count == $past(count) + 1'b1));
  // R8: no restart while repeat is off
  a_r8_no_restart_off: assert property (@(posedge clk_in) disable iff (!rst_n)
    !repeat_en |=> !restart);
  // R8: restart only with count reading zero
  a_r8_restart_at_zero: assert property (@(posedge clk_in) disable iff (!rst_n)
    restart |-> (count == '0));
endmodule

// File: rtl/panel_out_stage.sv
module panel_out_stage #(
  parameter int PIX_W   = 18,
  parameter int FRAME_W = 18
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               cfg_div2,
  input  logic               cfg_blank,
  input  logic               cfg_repeat,
  input  logic               cfg_hw_inv_en,
  input  logic               cfg_sw_inv,
  input  logic               panel_active,
  input  logic               shared_pin,
  input  logic               frame_start,
  input  logic               pix_in_valid,
  output logic               pix_in_ready,
  input  logic [PIX_W-1:0]   pix_in_data,
  output logic               pix_out_valid,
  input  logic               pix_out_ready,
  output logic [PIX_W-1:0]   pix_out_data,
  output logic               clk_op,
  output logic               gpio_in,
  output logic [FRAME_W-1:0] frame_count,
  output logic               pattern_restart
);
  logic inv_on;

  po_clk_halver u_clk (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .div_sel(cfg_div2),
    .clk_op (clk_op)
  );

  po_invert_select u_inv (
    .cfg_hw_inv_en(cfg_hw_inv_en),
    .cfg_sw_inv   (cfg_sw_inv),
    .panel_active (panel_active),
    .shared_pin   (shared_pin),
    .inv_on       (inv_on),
    .gpio_in      (gpio_in)
  );

  po_pixel_stage #(.PIX_W(PIX_W)) u_pix (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .blank    (cfg_blank),
    .inv_on   (inv_on),
    .in_valid (pix_in_valid),
    .in_ready (pix_in_ready),
    .in_data  (pix_in_data),
    .out_valid(pix_out_valid),
    .out_ready(pix_out_ready),
    .out_data (pix_out_data)
  );

  po_frame_tally #(.FRAME_W(FRAME_W)) u_frm (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .repeat_en  (cfg_repeat),
    .count      (frame_count),
    .restart    (pattern_restart)
  );

  // R6: ready rule at the boundary
  a_r6_ready_rule: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!pix_out_valid) |-> pix_in_ready);
  // R9: reset leaves nothing valid
  a_r9_reset_idle: assert property (@(posedge clk_in)
    (!rst_n) |=> (!pix_out_valid || rst_n));
endmodule

// File: tb/sim_panel_out_stage.sv
module sim_panel_out_stage;
  localparam int PW = 18;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_div2 = 0, cfg_blank = 0, cfg_repeat = 0, cfg_hw_inv_en = 0, cfg_sw_inv = 0;
  logic panel_active = 0, shared_pin = 0, frame_start = 0;
  logic pix_in_valid = 0, pix_out_ready = 1;
  logic [PW-1:0] pix_in_data = '0;
  logic pix_in_ready, pix_out_valid, clk_op, gpio_in, pattern_restart;
  logic [PW-1:0] pix_out_data;
  logic [FW-1:0] frame_count;

  int total = 0, bad = 0;
  logic [PW-1:0] sb_q[$];
  logic bp_on = 0;
  logic [7:0] lfsr = 8'h5a;
  bit done = 0;

  always #5 clk = ~clk;

  panel_out_stage #(.PIX_W(PW), .FRAME_W(FW)) u0 (
    .clk_in(clk), .rst_n(rst_n), .cfg_div2(cfg_div2), .cfg_blank(cfg_blank),
    .cfg_repeat(cfg_repeat), .cfg_hw_inv_en(cfg_hw_inv_en), .cfg_sw_inv(cfg_sw_inv),
    .panel_active(panel_active), .shared_pin(shared_pin), .frame_start(frame_start),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready), .pix_out_data(pix_out_data),
    .clk_op(clk_op), .gpio_in(gpio_in), .frame_count(frame_count),
    .pattern_restart(pattern_restart));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] model(input logic [PW-1:0] d);
    logic inv;
    if (cfg_blank) return '0;
    inv = (cfg_hw_inv_en && !panel_active) ? shared_pin : cfg_sw_inv;
    return inv ? ~d : d;
  endfunction

  // back-pressure pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pix_out_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  // monitor: R6 ready rule, hold, and scoreboard compare
  logic prev_stall = 0;
  logic [PW-1:0] prev_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_in_ready !== (!pix_out_valid || pix_out_ready))
        chk(0, "R6 ready", pix_in_ready, !pix_out_valid || pix_out_ready);
      if (prev_stall) begin
        total++;
        if (!(pix_out_valid && pix_out_data == prev_data)) begin
          bad++;
          $display("FAIL R6 hold actual=%0h expected=%0h", pix_out_data, prev_data);
        end
      end
      prev_stall = pix_out_valid && !pix_out_ready;
      prev_data  = pix_out_data;
      if (pix_out_valid && pix_out_ready) begin
        if (sb_q.size() == 0) chk(0, "R6 extra output", pix_out_data, 0);
        else begin
          logic [PW-1:0] e;
          e = sb_q.pop_front();
          chk(pix_out_data == e, "R2/R3/R4 data", pix_out_data, e);
        end
      end
    end
  end

  task automatic send(input logic [PW-1:0] d);
    @(posedge clk); #1;
    pix_in_valid = 1'b1;
    pix_in_data  = d;
    forever begin
      @(negedge clk);
      if (pix_in_ready) break;
    end
    sb_q.push_back(model(d));
    @(posedge clk); #1;
    pix_in_valid = 1'b0;
  endtask

  task automatic burst(input int n, input logic [PW-1:0] seed, input bit wiggle_pin);
    for (int i = 0; i < n; i++) begin
      if (wiggle_pin) shared_pin = i[0];
      send(seed ^ PW'(i * 32'h1357));
    end
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && sb_q.size() != 0; i++) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all delivered", sb_q.size(), 0);
  endtask

  task automatic strobe;
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_div2 = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state, R1 toggle low in reset
    chk(!pix_out_valid, "R9 out_valid", pix_out_valid, 0);
    chk(frame_count == 0, "R9 count", frame_count, 0);
    chk(!pattern_restart, "R9 restart", pattern_restart, 0);
    chk(clk_op == 1'b0, "R1 reset low", clk_op, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 divide by two: level alternates each input period
    begin
      logic a, b;
      @(negedge clk); a = clk_op;
      @(negedge clk); b = clk_op;
      chk(a != b, "R1 div2 toggles", b, !a);
      @(negedge clk);
      chk(clk_op == a, "R1 div2 period", clk_op, a);
    end
    cfg_div2 = 1'b0;
    @(posedge clk); #2;
    chk(clk_op == 1'b1, "R1 pass high", clk_op, 1);
    @(negedge clk); #2;
    chk(clk_op == 1'b0, "R1 pass low", clk_op, 0);

    // R5 gpio role
    panel_active = 0; cfg_hw_inv_en = 0; shared_pin = 1; #1;
    chk(gpio_in == 1'b1, "R5 gpio passes pin", gpio_in, 1);
    shared_pin = 0; #1;
    chk(gpio_in == 1'b0, "R5 gpio low pin", gpio_in, 0);
    cfg_hw_inv_en = 1; shared_pin = 1; #1;
    chk(gpio_in == 1'b0, "R5 gpio masked hw", gpio_in, 0);
    cfg_hw_inv_en = 0; panel_active = 1; #1;
    chk(gpio_in == 1'b0, "R5 gpio masked active", gpio_in, 0);
    panel_active = 0; shared_pin = 0;

    // R3 software invert, pin wiggled and ignored
    cfg_sw_inv = 0; burst(6, 18'h0f0f0, 1);
    cfg_sw_inv = 1; burst(6, 18'h2a5a5, 1);
    // R3 active panel: pin role off
    panel_active = 1; cfg_hw_inv_en = 1; cfg_sw_inv = 0; burst(6, 18'h11111, 1);
    cfg_sw_inv = 1; burst(4, 18'h3ffff, 1);
    drain();
    // R4 pin invert in passive mode, sw ignored
    panel_active = 0; cfg_hw_inv_en = 1; cfg_sw_inv = 1; burst(8, 18'h00ff0, 1);
    cfg_sw_inv = 0; burst(8, 18'h12345, 1);
    drain();
    // R6 back-pressure
    bp_on = 1;
    cfg_hw_inv_en = 0; cfg_sw_inv = 1; burst(24, 18'h0a0a0, 0);
    // R2 blank wins over invert
    cfg_blank = 1; burst(8, 18'h3c3c3, 1);
    cfg_blank = 0; burst(4, 18'h00001, 0);
    drain();
    bp_on = 0;

    // R7 counter steps, R8 restart gated off
    cfg_repeat = 0;
    for (int k = 1; k <= 16; k++) begin
      strobe();
      chk(frame_count == FW'(k), "R7 count step", frame_count, FW'(k));
      chk(!pattern_restart, "R8 no restart when off", pattern_restart, 0);
    end
    @(negedge clk);
    chk(frame_count == 0, "R7 hold without strobe", frame_count, 0);
    // R8 restart pulse on wrap
    cfg_repeat = 1;
    for (int k = 1; k <= 15; k++) begin
      strobe();
      chk(!pattern_restart, "R8 no early restart", pattern_restart, 0);
    end
    strobe();
    chk(frame_count == 0, "R7 wrap to zero", frame_count, 0);
    chk(pattern_restart == 1'b1, "R8 restart on wrap", pattern_restart, 1);
    @(negedge clk);
    chk(!pattern_restart, "R8 one cycle", pattern_restart, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule